// File: doc/BRIEF.md
# Read-After-Write Lag Classifier

This monitor watches the control strobes of a field buffer that is written and read as two independent serial streams. All strobes are sampled on one clock. It counts the clock cycles from the rising edge of a write restart strobe to the rising edge of the next read restart strobe. From that count it decides which generation of data the read stream will return. A short lag returns the previous field, a long lag returns the field now being written, and a middle band gives a mix that cannot be predicted.

The monitor also counts active write and read cycles since each restart. While the read stream follows the current field, it checks that the writer stays far enough ahead. It also checks two rules at each restart strobe: the strobe must have been low long enough, and the period that ends must have held enough active cycles. Each error is held in a sticky flag until the clear input is pulsed.

Top module: `lag_class_mon`

## Requirements
- R1: After reset, `lag_class` is 00 and all six flags are 0.
- R2: The lag L is the number of clock edges from the edge that samples a write restart rise to the edge that samples a read restart rise. A rise on both strobes at the same edge gives L = 0. When L ≤ 119, `lag_class` becomes 01 (previous field) in the cycle after the read restart rise.
- R3: When 120 ≤ L ≤ 599, `lag_class` becomes 10 (undetermined), and `flag_undet` becomes 1 at the same edge.
- R4: When L ≥ 600, `lag_class` becomes 11 (current field). The lag count stops at 1023, so any longer lag is also 11.
- R5: A read restart rise that comes before any write restart rise since reset sets `lag_class` to 00. `lag_class` changes only at a read restart rise.
- R6: A read restart classified 11 arms the gap check, and the next write restart rise disarms it. While armed, every read-active cycle (`rd_en` 1, `rd_rst` 0) needs write count minus read count > 600. Otherwise `err_gap` is set. The counts are the active cycles since each port's last restart.
- R7: A cycle is active on a port when its enable is 1 and its restart strobe is 0. A restart rise that ends a period of fewer than 130 active cycles sets `err_wr_short` or `err_rd_short`. Cycles with the enable at 0 are not counted. The first rise after reset is exempt.
- R8: A restart rise seen after fewer than 2 low cycles of that strobe sets `err_wr_space` or `err_rd_space`.
- R9: Flags stay set until `err_clr` is 1 at a clock edge. If a new violation occurs at the same edge as the clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_rst | input | 1 | Write restart strobe |
| wr_en | input | 1 | Write enable |
| rd_rst | input | 1 | Read restart strobe |
| rd_en | input | 1 | Read enable |
| err_clr | input | 1 | Clears all sticky flags |
| lag_class | output | 2 | 00 none, 01 previous, 10 undetermined, 11 current |
| flag_undet | output | 1 | Sticky: lag fell in the undetermined band |
| err_gap | output | 1 | Sticky: writer lead not above 600 |
| err_wr_short | output | 1 | Sticky: write period too short |
| err_rd_short | output | 1 | Sticky: read period too short |
| err_wr_space | output | 1 | Sticky: write strobe low time too short |
| err_rd_space | output | 1 | Sticky: read strobe low time too short |

## Verification
Every result is registered once. The class code and all flags show the outcome of the edge that sampled the triggering strobe or enable. The bench drives inputs on falling edges and samples one falling edge after the triggering rising edge. It counts falling edges so that a read restart lands on exactly edge L after the write restart. The lag and gap boundaries are each checked on both sides: 119/120, 599/600 and 1023, and the last passing and first failing read cycle.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  typedef enum logic [1:0] {
    CL_NONE  = 2'b00,
    CL_OLD   = 2'b01,
    CL_UNDET = 2'b10,
    CL_NEW   = 2'b11
  } lag_class_e;

  // region decision from a lag count and two thresholds
  function automatic lag_class_e classify(input int unsigned lag,
                                          input int unsigned old_max,
                                          input int unsigned new_min);
    if (lag <= old_max)      return CL_OLD;
    else if (lag >= new_min) return CL_NEW;
    else                     return CL_UNDET;
  endfunction

  // true when the writer lead is not strictly above the minimum
  function automatic logic gap_short(input int unsigned wr_cnt,
                                     input int unsigned rd_cnt,
                                     input int unsigned min_lead);
    return (wr_cnt <= rd_cnt + min_lead);
  endfunction
endpackage

// File: rtl/lcm_port.sv
module lcm_port #(
  parameter int PTR_W      = 12,
  parameter int MIN_ACTIVE = 130,
  parameter int MIN_LOW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             en,
  output logic             evt,
  output logic [PTR_W-1:0] cnt,
  output logic             short_hit,
  output logic             space_hit
);
  localparam int LOW_W = $clog2(MIN_LOW + 1);
  localparam logic [PTR_W-1:0] CNT_MAX = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] ACT_MIN = PTR_W'(MIN_ACTIVE);
  localparam logic [LOW_W-1:0] LOW_MIN = LOW_W'(MIN_LOW);

  logic             strobe_q;
  logic [LOW_W-1:0] low_cnt;
  logic             started;

  assign evt       = strobe & ~strobe_q;
  assign space_hit = evt & (low_cnt < LOW_MIN);
  assign short_hit = evt & started & (cnt < ACT_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      low_cnt  <= LOW_MIN;
      started  <= 1'b0;
      cnt      <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe)                 low_cnt <= '0;
      else if (low_cnt < LOW_MIN) low_cnt <= low_cnt + 1'b1;
      if (evt) started <= 1'b1;
      if (strobe)                     cnt <= '0;
      else if (en && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt == '0)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !en) |=> $stable(cnt)); // R7
endmodule

// File: rtl/lcm_lag.sv
module lcm_lag
  import lcm_pkg::*;
#(
  parameter int LAG_W   = 10,
  parameter int OLD_MAX = 119,
  parameter int NEW_MIN = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt,
  input  logic       rd_evt,
  output lag_class_e class_q,
  output logic       undet_hit,
  output logic       new_hit
);
  localparam logic [LAG_W-1:0] LAG_MAX = {LAG_W{1'b1}};

  logic [LAG_W-1:0] lag_q;
  logic             wr_seen;
  logic             seen_now;
  logic [LAG_W-1:0] cur_lag;
  lag_class_e       region;

  assign seen_now  = wr_seen | wr_evt;
  assign cur_lag   = wr_evt ? '0 : lag_q;
  assign region    = classify(32'(cur_lag), OLD_MAX, NEW_MIN);
  assign undet_hit = rd_evt & seen_now & (region == CL_UNDET);
  assign new_hit   = rd_evt & seen_now & (region == CL_NEW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag_q   <= '0;
      wr_seen <= 1'b0;
      class_q <= CL_NONE;
    end else begin
      if (wr_evt) begin
        lag_q   <= LAG_W'(1);
        wr_seen <= 1'b1;
      end else if (lag_q != LAG_MAX) begin
        lag_q <= lag_q + 1'b1;
      end
      if (rd_evt) class_q <= seen_now ? region : CL_NONE;
    end
  end

  AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(class_q)); // R5
endmodule

// File: rtl/lag_class_mon.sv
module lag_class_mon
  import lcm_pkg::*;
#(
  parameter int PTR_W      = 12,
  parameter int LAG_W      = 10,
  parameter int OLD_MAX    = 119,
  parameter int NEW_MIN    = 600,
  parameter int GAP_MIN    = 600,
  parameter int MIN_ACTIVE = 130,
  parameter int MIN_LOW    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_rst,
  input  logic       wr_en,
  input  logic       rd_rst,
  input  logic       rd_en,
  input  logic       err_clr,
  output logic [1:0] lag_class,
  output logic       flag_undet,
  output logic       err_gap,
  output logic       err_wr_short,
  output logic       err_rd_short,
  output logic       err_wr_space,
  output logic       err_rd_space
);
  localparam int NFLAG = 6;

  logic             wr_evt, rd_evt;
  logic [PTR_W-1:0] wr_cnt, rd_cnt;
  logic             wr_short_hit, rd_short_hit, wr_space_hit, rd_space_hit;
  logic             undet_hit, new_hit, gap_hit, rd_active;
  logic             armed;
  lag_class_e       class_q;
  logic [NFLAG-1:0] hits, flags;

  lcm_port #(.PTR_W(PTR_W), .MIN_ACTIVE(MIN_ACTIVE), .MIN_LOW(MIN_LOW)) u_wr (
    .clk(clk), .rst_n(rst_n), .strobe(wr_rst), .en(wr_en), .evt(wr_evt),
    .cnt(wr_cnt), .short_hit(wr_short_hit), .space_hit(wr_space_hit));

  lcm_port #(.PTR_W(PTR_W), .MIN_ACTIVE(MIN_ACTIVE), .MIN_LOW(MIN_LOW)) u_rd (
    .clk(clk), .rst_n(rst_n), .strobe(rd_rst), .en(rd_en), .evt(rd_evt),
    .cnt(rd_cnt), .short_hit(rd_short_hit), .space_hit(rd_space_hit));

  lcm_lag #(.LAG_W(LAG_W), .OLD_MAX(OLD_MAX), .NEW_MIN(NEW_MIN)) u_lag (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .class_q(class_q), .undet_hit(undet_hit), .new_hit(new_hit));

  assign rd_active = rd_en & ~rd_rst;
  assign gap_hit   = armed & rd_active & gap_short(32'(wr_cnt), 32'(rd_cnt), GAP_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (wr_evt)  armed <= 1'b0;
    else if (new_hit) armed <= 1'b1;
  end

  assign hits = {rd_space_hit, wr_space_hit, rd_short_hit, wr_short_hit, gap_hit, undet_hit};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] & ~err_clr) | hits[i];
    end
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(err_clr)); // R9
  end

  assign lag_class    = class_q;
  assign flag_undet   = flags[0];
  assign err_gap      = flags[1];
  assign err_wr_short = flags[2];
  assign err_rd_short = flags[3];
  assign err_wr_space = flags[4];
  assign err_rd_space = flags[5];

  AST_WARN_WITH_UNDET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_undet) |-> (lag_class == CL_UNDET)); // R3
  AST_GAP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_gap) |-> ($past(rd_en) && !$past(rd_rst))); // R6
endmodule

// File: tb/lag_class_mon_tb.sv
module lag_class_mon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_rst = 1'b0, wr_en = 1'b0, rd_rst = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
  logic [1:0] lag_class;
  logic flag_undet, err_gap, err_wr_short, err_rd_short, err_wr_space, err_rd_space;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  lag_class_mon u_dut (.clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en),
    .rd_rst(rd_rst), .rd_en(rd_en), .err_clr(err_clr), .lag_class(lag_class),
    .flag_undet(flag_undet), .err_gap(err_gap), .err_wr_short(err_wr_short),
    .err_rd_short(err_rd_short), .err_wr_space(err_wr_space), .err_rd_space(err_rd_space));

  localparam int NV = 9;
  localparam int LAGS [NV] = '{0, 1, 119, 120, 300, 599, 600, 1023, 1500};
  localparam logic [1:0] EXP [NV] = '{2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b11};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // write restart, then read restart exactly lag edges later; check one edge after
  task automatic run_lag(input int lag, input logic [1:0] exp, input string req);
    @(negedge clk); wr_rst = 1'b1; if (lag == 0) rd_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0; rd_rst = 1'b0;
    if (lag > 0) begin
      repeat (lag - 1) @(negedge clk);
      rd_rst = 1'b1;
      @(negedge clk); rd_rst = 1'b0;
    end
    chk(req, 32'(lag_class), 32'(exp));
    idle(3);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 class", 32'(lag_class), 0);
    chk("R1 flags", 32'({flag_undet, err_gap, err_wr_short, err_rd_short, err_wr_space, err_rd_space}), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 class after release", 32'(lag_class), 0);

    // R5 read restart before any write restart
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
    chk("R5 no write yet", 32'(lag_class), 0);
    idle(3);

    // table of lags: R2 / R3 / R4
    for (int i = 0; i < NV; i++) begin
      clear_flags();
      run_lag(LAGS[i], EXP[i], (EXP[i] == 2'b01) ? "R2 old" : (EXP[i] == 2'b10) ? "R3 undet" : "R4 new");
      chk("R3 warn follows band", 32'(flag_undet), (EXP[i] == 2'b10) ? 1 : 0);
    end

    // R5 class holds with no read restart
    @(negedge clk); wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0;
    idle(150);
    chk("R5 class held", 32'(lag_class), 32'(2'b11));

    // R9 clear, and set wins over clear
    clear_flags();
    chk("R9 cleared", 32'({flag_undet, err_gap, err_wr_short, err_rd_short, err_wr_space, err_rd_space}), 0);
    @(negedge clk); wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0;
    idle(199);
    err_clr = 1'b1; rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
    chk("R9 set wins", 32'(flag_undet), 1);
    idle(2);
    chk("R9 cleared by held clear", 32'(flag_undet), 0);
    err_clr = 1'b0;
    idle(2);
    chk("R9 stays clear", 32'(flag_undet), 0);

    // R8 spacing: one low cycle is an error, two is fine
    @(negedge clk); wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0; err_clr = 1'b1;
    @(negedge clk); wr_rst = 1'b1; err_clr = 1'b0;
    @(negedge clk); wr_rst = 1'b0;
    chk("R8 write spacing", 32'(err_wr_space), 1);
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
    chk("R8 read spacing ok", 32'(err_rd_space), 0);
    idle(3);

    // R7 short periods
    @(negedge clk); wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0; wr_en = 1'b1; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    repeat (128) @(negedge clk);
    wr_en = 1'b0; wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0;
    chk("R7 write 129 active", 32'(err_wr_short), 1);
    wr_en = 1'b1; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    repeat (129) @(negedge clk);
    wr_en = 1'b0;
    idle(20);
    wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0;
    chk("R7 write 130 active, idle not counted", 32'(err_wr_short), 0);
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0; rd_en = 1'b1; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    repeat (128) @(negedge clk);
    rd_en = 1'b0; rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
    chk("R7 read 129 active", 32'(err_rd_short), 1);
    idle(3);

    // R6 gap check at its boundary
    @(negedge clk); wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0; wr_en = 1'b1;
    repeat (699) @(negedge clk);
    rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0; rd_en = 1'b1; err_clr = 1'b1;
    chk("R6 class new", 32'(lag_class), 32'(2'b11));
    @(negedge clk); err_clr = 1'b0;
    repeat (49) @(negedge clk);
    chk("R6 lead held", 32'(err_gap), 0);
    wr_en = 1'b0;
    repeat (100) @(negedge clk);
    chk("R6 lead 601", 32'(err_gap), 0);
    @(negedge clk);
    chk("R6 lead 600", 32'(err_gap), 1);
    // R6 disarm after write restart
    rd_en = 1'b0; wr_rst = 1'b1;
    @(negedge clk); wr_rst = 1'b0; rd_en = 1'b1; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    idle(20);
    chk("R6 disarmed", 32'(err_gap), 0);
    rd_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule